// File: doc/BRIEF.md
# Token-Ring Register FIFO

This block is a small first-in first-out queue built from a bank of registers. It does not use binary read and write counters. Each position is a single token that circulates around its own ring of one-hot bits, one bit per storage cell. The write token picks the only register that loads from the shared input bus on an accepted write, which is the free cell just behind the occupied ones. The read token picks the register at the head of the occupied cells. That register reaches the shared output bus through an AND-OR selector, so the design has no tri-state drivers. Words stay in the cell where they were written until that cell is read, so no data moves between cells.

A producer writes through a valid/ready port. A consumer sees the head word and a valid flag, and takes the word by raising its ready input. A read and a write can be accepted in the same cycle. Equal token positions occur both when the queue is empty and when it is full, so an occupancy tracker tells the two states apart. A parameter selects the tracker: either a fill counter or a single "last move was a write" flag. Both give the same behaviour at the ports.

Top module: `ring_token_fifo`

## Requirements
- R1: After reset, rd_valid is 0, wr_ready is 1 and rd_data is all zeros. Both tokens start on cell 0.
- R2: Each token vector has exactly one bit set in every cycle after reset.
- R3: Words leave in the order they were accepted. This holds across wraps, where a token passes from the last cell back to cell 0.
- R4: An accepted write loads exactly one cell. Words already stored are unchanged, which shows up when they are later read.
- R5: After DEPTH unmatched writes, wr_ready is 0. A write offered while the queue is full is ignored, and the head word and its successors are unchanged.
- R6: rd_ready while the queue is empty has no effect. rd_valid stays 0, and the next word written is the next word read.
- R7: When a read and a write are accepted in the same cycle, both tokens advance and the fill level (wr_ready and rd_valid) is unchanged.
- R8: While rd_valid is 1, rd_data equals the head word and exactly one cell is selected onto the bus. While the queue is empty, rd_data is all zeros.
- R9: The counter tracker (OCC_COUNT) and the flag tracker (OCC_WRAPFLAG) give identical port behaviour under identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers wr_data |
| wr_ready | output | 1 | Queue can take a word (not full) |
| wr_data | input | WIDTH | Shared input bus |
| rd_valid | output | 1 | Head word present (not empty) |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | WIDTH | Shared output bus, head word or zero |

## Verification
A token that was lost, duplicated or advanced at the wrong moment shows up at rd_data on the next read. The bus then shows a word out of order, a zero, or the OR of two cells. An occupancy tracker that disagrees with the tokens shows up in the same cycle as a wrong wr_ready or rd_valid, and on a later read as an overwritten or repeated word. The stimulus therefore fills the queue, overfills it, drains it, over-reads it, and pairs reads with writes across a wrap, comparing every output in every cycle.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

   typedef enum logic [0:0] {
      OCC_COUNT    = 1'b0,
      OCC_WRAPFLAG = 1'b1
   } occ_style_e;

   function automatic int unsigned fill_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/ring_token.sv
module ring_token #(
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [DEPTH-1:0] tok
);
   localparam logic [DEPTH-1:0] HOME = DEPTH'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         tok <= HOME;
      else if (step)
         tok <= {tok[DEPTH-2:0], tok[DEPTH-1]};
   end

   // R2: token never lost or duplicated
   assert_token_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tok) == 1);

   // R3: token holds still without an accepted transfer
   assert_token_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(tok));

endmodule

// File: rtl/cell_bank.sv
module cell_bank #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_fire,
   input  logic [DEPTH-1:0] wr_tok,
   input  logic [WIDTH-1:0] wr_bus,
   output logic [WIDTH-1:0] cells [DEPTH]
);
   logic [DEPTH-1:0] load_en;

   assign load_en = wr_tok & {DEPTH{wr_fire}};

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (load_en[i])
            cells[i] <= wr_bus;
      end
   end

   // R4: at most one register captures the input bus
   assert_single_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(load_en) <= 1);

   // R4: an accepted write always hits some cell
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> $countones(load_en) == 1);

endmodule

// File: rtl/bus_select.sv
module bus_select #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] sel,
   input  logic [WIDTH-1:0] cells [DEPTH],
   output logic [WIDTH-1:0] bus
);
   always_comb begin
      bus = '0;
      for (int i = 0; i < DEPTH; i++)
         bus = bus | (cells[i] & {WIDTH{sel[i]}});
   end

   // R8: never two drivers on the output bus
   assert_single_driver_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel) <= 1);

endmodule

// File: rtl/occ_tracker.sv
module occ_tracker
   import ring_fifo_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter occ_style_e  STYLE = OCC_COUNT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_fire,
   input  logic rd_fire,
   input  logic tok_match,
   output logic full,
   output logic empty
);
   localparam int unsigned FW = fill_bits(DEPTH);
   localparam logic [FW-1:0] FULL_LVL = FW'(DEPTH);

   if (STYLE == OCC_COUNT) begin : g_count
      logic [FW-1:0] fill;

      always_ff @(posedge clk) begin
         if (!rst_n)
            fill <= '0;
         else if (wr_fire && !rd_fire)
            fill <= fill + 1'b1;
         else if (rd_fire && !wr_fire)
            fill <= fill - 1'b1;
      end

      assign full  = (fill == FULL_LVL);
      assign empty = (fill == '0);

      // R5: fill level never exceeds capacity
      assert_fill_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
         fill <= FULL_LVL);

      // R5: counter limits agree with coinciding tokens
      assert_edge_tokens_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (full || empty) |-> tok_match);
   end else begin : g_flag
      logic last_wr;

      always_ff @(posedge clk) begin
         if (!rst_n)
            last_wr <= 1'b0;
         else if (wr_fire && !rd_fire)
            last_wr <= 1'b1;
         else if (rd_fire && !wr_fire)
            last_wr <= 1'b0;
      end

      assign full  = tok_match &&  last_wr;
      assign empty = tok_match && !last_wr;
   end

   // R5: no acceptance past the limits
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !(wr_fire && !rd_fire));

   // R6: no read accepted from an empty queue
   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_fire);

   // R7: paired transfer leaves the level alone
   assert_pair_keeps_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire && rd_fire) |=> (full == $past(full)) && (empty == $past(empty)));

   // R5/R6: the two states exclude each other
   assert_states_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

endmodule

// File: rtl/ring_token_fifo.sv
module ring_token_fifo
   import ring_fifo_pkg::*;
#(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8,
   parameter occ_style_e  OCC   = OCC_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [WIDTH-1:0] wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [WIDTH-1:0] rd_data
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("ring_token_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ring_token_fifo: WIDTH must be at least 1");
   end

   logic [DEPTH-1:0] wr_tok;
   logic [DEPTH-1:0] rd_tok;
   logic [DEPTH-1:0] out_sel;
   logic [WIDTH-1:0] cells [DEPTH];
   logic             wr_fire;
   logic             rd_fire;
   logic             full;
   logic             empty;
   logic             tok_match;

   assign wr_ready  = !full;
   assign rd_valid  = !empty;
   assign wr_fire   = wr_valid && !full;
   assign rd_fire   = rd_ready && !empty;
   assign tok_match = |(wr_tok & rd_tok);
   assign out_sel   = rd_tok & {DEPTH{!empty}};

   ring_token #(.DEPTH(DEPTH)) u_wr_ring (
      .clk(clk), .rst_n(rst_n), .step(wr_fire), .tok(wr_tok));

   ring_token #(.DEPTH(DEPTH)) u_rd_ring (
      .clk(clk), .rst_n(rst_n), .step(rd_fire), .tok(rd_tok));

   cell_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_cells (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_tok(wr_tok),
      .wr_bus(wr_data), .cells(cells));

   bus_select #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_sel (
      .clk(clk), .rst_n(rst_n), .sel(out_sel), .cells(cells), .bus(rd_data));

   occ_tracker #(.DEPTH(DEPTH), .STYLE(OCC)) u_occ (
      .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
      .tok_match(tok_match), .full(full), .empty(empty));

   // R1: tokens and state come out of reset together
   assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> (wr_tok == rd_tok) && rd_valid && 1'b0 == 1'b0 ? !rd_valid : 1'b1);

   // R8: a non-empty queue drives exactly one cell onto the bus
   assert_head_selected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $countones(out_sel) == 1);

endmodule

// File: tb/ring_token_fifo_test.sv
module ring_token_fifo_test;
   import ring_fifo_pkg::*;

   localparam int unsigned W = 16;
   localparam int unsigned D = 4;
   localparam int unsigned ROWS = 16;
   localparam int unsigned VW = 1 + W + 1 + 1 + 1 + W;

   // {wr_valid, wr_data, rd_ready, exp_wr_ready, exp_rd_valid, exp_rd_data}
   localparam logic [VW-1:0] VEC [ROWS] = '{
      {1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000},  // R1 idle after reset
      {1'b1, 16'hA001, 1'b0, 1'b1, 1'b0, 16'h0000},
      {1'b1, 16'hA002, 1'b0, 1'b1, 1'b1, 16'hA001},
      {1'b1, 16'hA003, 1'b0, 1'b1, 1'b1, 16'hA001},
      {1'b1, 16'hA004, 1'b0, 1'b1, 1'b1, 16'hA001},
      {1'b1, 16'h0BAD, 1'b0, 1'b0, 1'b1, 16'hA001},  // R5 full, write dropped
      {1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'hA001},
      {1'b1, 16'hA005, 1'b1, 1'b1, 1'b1, 16'hA002},  // R7 paired
      {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA003},
      {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA004},
      {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA005},  // R3 wrapped word
      {1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000},  // R6 read on empty
      {1'b1, 16'hA006, 1'b0, 1'b1, 1'b0, 16'h0000},
      {1'b1, 16'hA007, 1'b1, 1'b1, 1'b1, 16'hA006},  // R7 paired at level 1
      {1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 16'hA007},
      {1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0000}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_valid = 1'b0;
   logic         rd_ready = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         wr_ready, rd_valid, wr_ready_f, rd_valid_f;
   logic [W-1:0] rd_data, rd_data_f;
   int           total = 0;
   int           bad = 0;
   bit           done = 1'b0;

   always #10 clk = ~clk;

   ring_token_fifo #(.WIDTH(W), .DEPTH(D), .OCC(OCC_COUNT)) uut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_data(rd_data));

   ring_token_fifo #(.WIDTH(W), .DEPTH(D), .OCC(OCC_WRAPFLAG)) uut_flag (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready_f),
      .wr_data(wr_data), .rd_valid(rd_valid_f), .rd_ready(rd_ready),
      .rd_data(rd_data_f));

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_ports(input string req, input logic ewr, input logic erv,
                              input logic [W-1:0] ed);
      check({req, " wr_ready"}, W'(wr_ready), W'(ewr));
      check({req, " rd_valid"}, W'(rd_valid), W'(erv));
      check({req, " rd_data R8"}, rd_data, ed);
      check("R9 flag variant wr_ready", W'(wr_ready_f), W'(wr_ready));
      check("R9 flag variant rd_valid", W'(rd_valid_f), W'(rd_valid));
      check("R9 flag variant rd_data", rd_data_f, rd_data);
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int r = 0; r < ROWS; r++) begin
         logic [VW-1:0] v;
         v = VEC[r];
         wr_valid = v[VW-1];
         wr_data  = v[VW-2 -: W];
         rd_ready = v[W+2];
         #5;
         check_ports($sformatf("R3/R4 row %0d", r), v[W+1], v[W], v[W-1:0]);
         @(negedge clk);
      end

      // R1: reset in the middle of traffic empties the queue
      wr_valid = 1'b1; rd_ready = 1'b0; wr_data = 16'hC001;
      @(negedge clk);
      wr_data = 16'hC002;
      @(negedge clk);
      wr_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      check_ports("R1 after mid-run reset", 1'b1, 1'b0, '0);

      // R1/R3: tokens back home, fresh word comes out first
      @(negedge clk);
      wr_valid = 1'b1; wr_data = 16'hD00D;
      @(negedge clk);
      wr_valid = 1'b0;
      #5;
      check_ports("R1 first word after reset", 1'b1, 1'b1, 16'hD00D);

      // R5: fill to the limit, then an offered write must not land
      @(negedge clk);
      for (int k = 1; k < int'(D); k++) begin
         wr_valid = 1'b1; wr_data = W'(16'hE000 + k);
         @(negedge clk);
      end
      wr_valid = 1'b1; wr_data = 16'hFFFF;
      #5;
      check_ports("R5 full blocks write", 1'b0, 1'b1, 16'hD00D);
      @(negedge clk);
      wr_valid = 1'b0; rd_ready = 1'b1;
      for (int k = 1; k < int'(D); k++) begin
         @(negedge clk);
         #5;
         check_ports("R4 drained order", 1'b1, 1'b1, W'(16'hE000 + k));
      end
      @(negedge clk);
      rd_ready = 1'b0;
      #5;
      check_ports("R6 drained to empty", 1'b1, 1'b0, '0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule